// File: doc/BRIEF.md
# Multi-format stereo audio serial receiver

This block turns a serial audio stream into parallel stereo samples. It is a slave: the bit clock, the channel (word) clock and the serial data line all come from outside and are brought into the system clock domain through synchronizer chains. Every rising bit-clock edge samples one data bit, most significant bit first. A framing format decides which of those bits belong to the left sample and which to the right.

Four framings are supported. The first is the classic inter-IC sound layout, in which the MSB is delayed by one bit. The second is left-aligned, with the MSB on the first bit. The third is right-aligned, with the LSB on the last bit of the half-frame. The fourth is a pulse-framed layout, in which a short frame pulse opens a frame and the left and right words follow back to back. Two packed-stream codes capture the first slot of each half-frame. One uses the left-aligned timing and the other uses the one-bit-delayed timing. Each sample can be 16, 20 or 24 bits wide. It is sign-extended to 24 bits and presented with a one-cycle strobe for its channel.

Top module: `aud_serial_rx`

## Requirements
- R1: While reset is asserted and just after it, both sample outputs are zero and both strobes are low.
- R2: `width_sel` picks the sample width: 00 = 24 bits, 01 = 20 bits, 10 = 16 bits, 11 = 24 bits. The received word is sign-extended from its top bit to 24 bits.
- R3: `fmt_sel` 000 selects one-bit-delayed framing (codes 110 and 111 act the same). A channel-clock level change is first seen on rising edge 0. The MSB is taken on rising edge 1 after the change, and the word ends on edge W. Channel clock low means left and high means right.
- R4: `fmt_sel` 011 selects left-aligned framing. The MSB is taken on rising edge 0, which is the first edge that sees the new channel-clock level, and the word ends on edge W-1.
- R5: `fmt_sel` 001 selects right-aligned framing. The word is the last W bits before a channel-clock change and belongs to the channel of the old level. It is delivered when the change is seen.
- R6: `fmt_sel` 010 selects pulse framing. The first rising edge that sees the channel clock high after it was low is edge 0. The left word occupies edges 1..W and the right word occupies edges W+1..2W. The channel-clock level does not name the channel.
- R7: `fmt_sel` 100 captures the first slot of each half-frame with R4 timing, and `fmt_sel` 101 does the same with R3 timing.
- R8: Each strobe lasts one system clock. Each channel gets exactly one strobe per frame.
- R9: Without rising bit-clock edges, changes on the data line or the channel clock produce no strobe and leave the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bclk_in | input | 1 | Serial bit clock (asynchronous) |
| lrclk_in | input | 1 | Channel clock or frame pulse (asynchronous) |
| sdata_in | input | 1 | Serial data, MSB first |
| fmt_sel | input | 3 | Framing format code |
| width_sel | input | 2 | Sample width code |
| left_sample | output | 24 | Last left sample, sign-extended |
| left_strobe | output | 1 | One-cycle pulse when a new left sample is available |
| right_sample | output | 24 | Last right sample, sign-extended |
| right_strobe | output | 1 | One-cycle pulse when a new right sample is available |

## Verification
The right-aligned right-channel word is the hardest case to observe. It is only delivered when the next frame opens, so a stream that simply stops after the right half never shows it. The stimulus sends three frames for every format and width and then two trailing bits at the left level. This forces that last edge. The expected strobe count for right-aligned framing therefore includes the previous frame's right word. Format switches happen mid-stream, so the first frame after each switch is treated as settling and is left out of the counts.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;
  localparam int SAMPLE_W = 24;

  typedef enum logic [1:0] {
    ALIGN_LEAD0,  // MSB on first edge of half-frame
    ALIGN_LEAD1,  // MSB one edge later
    ALIGN_TAIL,   // LSB on last edge of half-frame
    ALIGN_PULSE   // frame pulse, left then right
  } align_e;

  function automatic align_e fmt_align(input logic [2:0] f);
    case (f)
      3'b001:  return ALIGN_TAIL;
      3'b010:  return ALIGN_PULSE;
      3'b011:  return ALIGN_LEAD0;
      3'b100:  return ALIGN_LEAD0;
      default: return ALIGN_LEAD1;
    endcase
  endfunction

  function automatic logic [4:0] width_bits(input logic [1:0] code);
    case (code)
      2'b01:   return 5'd20;
      2'b10:   return 5'd16;
      default: return 5'd24;
    endcase
  endfunction

  function automatic logic [SAMPLE_W-1:0] sext_word(input logic [SAMPLE_W-1:0] raw,
                                                    input logic [4:0] n);
    logic [4:0] sh;
    logic [SAMPLE_W-1:0] up;
    sh = 5'(SAMPLE_W) - n;
    up = raw << sh;
    return $unsigned($signed(up) >>> sh);
  endfunction
endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_a,
  input  logic lrclk_a,
  input  logic sdata_a,
  output logic rise_evt,
  output logic lr_s,
  output logic sd_s
);
  localparam int NSIG = 3;
  logic [NSIG-1:0] chain [STAGES];
  logic            bclk_d;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= {bclk_a, lrclk_a, sdata_a};
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bclk_d <= 1'b0;
    else        bclk_d <= chain[STAGES-1][2];

  assign rise_evt = chain[STAGES-1][2] & ~bclk_d;
  assign lr_s     = chain[STAGES-1][1];
  assign sd_s     = chain[STAGES-1][0];
endmodule

// File: rtl/aud_rx_frame.sv
module aud_rx_frame
  import aud_rx_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rise_evt,
  input  logic                lr_s,
  input  logic                sd_s,
  input  logic [2:0]          fmt,
  input  logic [1:0]          wcode,
  output logic                cap_evt,
  output logic                cap_right,
  output logic [SAMPLE_W-1:0] cap_word
);
  localparam logic [CNT_W-1:0] POS_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0]    pos, pos_nx, nb, nb2;
  logic [SAMPLE_W-1:0] shreg, shreg_nx;
  logic                lr_prev, lr_edge, frame_start, done;
  align_e              kind;

  always_comb begin
    kind        = fmt_align(fmt);
    nb          = CNT_W'(width_bits(wcode));
    nb2         = nb << 1;
    lr_edge     = lr_s ^ lr_prev;
    frame_start = (kind == ALIGN_PULSE) ? (lr_s & ~lr_prev) : lr_edge;
    pos_nx      = frame_start ? '0 : ((pos == POS_MAX) ? pos : pos + 1'b1);
    shreg_nx    = {shreg[SAMPLE_W-2:0], sd_s};
    done        = 1'b0;
    cap_right   = lr_s;
    cap_word    = shreg_nx;
    unique case (kind)
      ALIGN_LEAD0: done = (pos_nx == nb - CNT_W'(1));
      ALIGN_LEAD1: done = (pos_nx == nb);
      ALIGN_TAIL: begin
        done      = lr_edge && (pos != POS_MAX);
        cap_right = lr_prev;
        cap_word  = shreg;
      end
      ALIGN_PULSE: begin
        if (pos_nx == nb) begin
          done      = 1'b1;
          cap_right = 1'b0;
        end else if (pos_nx == nb2) begin
          done      = 1'b1;
          cap_right = 1'b1;
        end
      end
    endcase
    cap_evt = rise_evt & done;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pos     <= POS_MAX;
      shreg   <= '0;
      lr_prev <= 1'b0;
    end else if (rise_evt) begin
      pos     <= pos_nx;
      shreg   <= shreg_nx;
      lr_prev <= lr_s;
    end
endmodule

// File: rtl/aud_rx_out.sv
module aud_rx_out
  import aud_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap_evt,
  input  logic                cap_right,
  input  logic [SAMPLE_W-1:0] cap_word,
  input  logic [1:0]          wcode,
  output logic [SAMPLE_W-1:0] left_q,
  output logic                left_v,
  output logic [SAMPLE_W-1:0] right_q,
  output logic                right_v
);
  logic [SAMPLE_W-1:0] ext;
  assign ext = sext_word(cap_word, width_bits(wcode));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      left_q  <= '0;
      right_q <= '0;
      left_v  <= 1'b0;
      right_v <= 1'b0;
    end else begin
      left_v  <= cap_evt & ~cap_right;
      right_v <= cap_evt &  cap_right;
      if (cap_evt & ~cap_right) left_q  <= ext;
      if (cap_evt &  cap_right) right_q <= ext;
    end
endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
  import aud_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bclk_in,
  input  logic        lrclk_in,
  input  logic        sdata_in,
  input  logic [2:0]  fmt_sel,
  input  logic [1:0]  width_sel,
  output logic [23:0] left_sample,
  output logic        left_strobe,
  output logic [23:0] right_sample,
  output logic        right_strobe
);
  logic                rise_evt, lr_s, sd_s;
  logic                cap_evt, cap_right;
  logic [SAMPLE_W-1:0] cap_word;

  aud_rx_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .bclk_a(bclk_in), .lrclk_a(lrclk_in),
    .sdata_a(sdata_in), .rise_evt(rise_evt), .lr_s(lr_s), .sd_s(sd_s));

  aud_rx_frame #(.CNT_W(CNT_W)) frame_i (
    .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .lr_s(lr_s), .sd_s(sd_s),
    .fmt(fmt_sel), .wcode(width_sel), .cap_evt(cap_evt),
    .cap_right(cap_right), .cap_word(cap_word));

  aud_rx_out out_i (
    .clk(clk), .rst_n(rst_n), .cap_evt(cap_evt), .cap_right(cap_right),
    .cap_word(cap_word), .wcode(width_sel), .left_q(left_sample),
    .left_v(left_strobe), .right_q(right_sample), .right_v(right_strobe));
endmodule

// File: rtl/aud_serial_rx_chk.sv
module aud_serial_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rise_evt,
  input logic [1:0]  width_sel,
  input logic [23:0] left_sample,
  input logic        left_strobe,
  input logic [23:0] right_sample,
  input logic        right_strobe
);
  p_left_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    left_strobe |=> !left_strobe);
  p_right_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    right_strobe |=> !right_strobe);
  p_one_channel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(left_strobe && right_strobe));
  p_left_needs_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    left_strobe |-> $past(rise_evt));
  p_right_needs_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
    right_strobe |-> $past(rise_evt));
  p_left_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !left_strobe |-> left_sample == $past(left_sample));
  p_right_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !right_strobe |-> right_sample == $past(right_sample));
  p_sext16_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (left_strobe && width_sel == 2'b10) |-> left_sample[23:16] == {8{left_sample[15]}});
  p_sext20_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (right_strobe && width_sel == 2'b01) |-> right_sample[23:20] == {4{right_sample[19]}});
endmodule

bind aud_serial_rx aud_serial_rx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .width_sel(width_sel),
  .left_sample(left_sample), .left_strobe(left_strobe),
  .right_sample(right_sample), .right_strobe(right_strobe));

// File: tb/aud_serial_rx_tb_top.sv
module aud_serial_rx_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b1, lrclk = 1'b1, sdata = 1'b0;
  logic [2:0]  fmt = 3'b000;
  logic [1:0]  wsel = 2'b00;
  logic [23:0] lq, rq;
  logic        lv, rv;

  int checks = 0, failures = 0;
  int lcnt = 0, rcnt = 0, dbl = 0;
  logic [23:0] l_last = '0, r_last = '0;
  logic lv_d = 1'b0, rv_d = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  aud_serial_rx dut_i (
    .clk(clk), .rst_n(rst_n), .bclk_in(bclk), .lrclk_in(lrclk), .sdata_in(sdata),
    .fmt_sel(fmt), .width_sel(wsel), .left_sample(lq), .left_strobe(lv),
    .right_sample(rq), .right_strobe(rv));

  always @(negedge clk) begin
    if (lv) begin lcnt++; l_last = lq; end
    if (rv) begin rcnt++; r_last = rq; end
    if ((lv && lv_d) || (rv && rv_d)) dbl++;
    lv_d = lv; rv_d = rv;
  end

  typedef struct packed {
    logic [2:0]  f;
    logic [1:0]  wc;
    logic [23:0] l;
    logic [23:0] r;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{3'b000, 2'b00, 24'h123456, 24'h9ABCDE},  // R3
    '{3'b000, 2'b10, 24'h008001, 24'h007FFE},  // R3 R2
    '{3'b011, 2'b00, 24'hA5A5A5, 24'h0F1E2D},  // R4
    '{3'b011, 2'b01, 24'h080000, 24'h012345},  // R4 R2
    '{3'b001, 2'b00, 24'h800001, 24'h7FFFFF},  // R5
    '{3'b001, 2'b10, 24'h00C3C3, 24'h001234},  // R5 R2
    '{3'b010, 2'b00, 24'hDEADBE, 24'h012345},  // R6
    '{3'b010, 2'b01, 24'h09ABCD, 24'h054321},  // R6 R2
    '{3'b100, 2'b00, 24'h5A5A5A, 24'hC0FFEE},  // R7
    '{3'b101, 2'b10, 24'h00BEEF, 24'h000042},  // R7
    '{3'b000, 2'b11, 24'hF00F0F, 24'h0FF0F0},  // R2 reserved width
    '{3'b110, 2'b00, 24'h314159, 24'hA27182}   // R3 reserved format
  };

  function automatic int wbits(input logic [1:0] c);
    if (c == 2'b01) return 20;
    if (c == 2'b10) return 16;
    return 24;
  endfunction

  function automatic logic [23:0] expect_ext(input logic [23:0] s, input int w);
    logic [23:0] e;
    for (int i = 0; i < 24; i++) e[i] = (i < w) ? s[i] : s[w-1];
    return e;
  endfunction

  // returns {lrclk, data} for bit k (0..63) of a frame
  function automatic logic [1:0] frame_bit(input logic [2:0] f, input int w,
                                           input logic [23:0] l, input logic [23:0] r,
                                           input int k);
    int j;
    logic [23:0] s;
    logic lr, d;
    j  = k % 32;
    s  = (k >= 32) ? r : l;
    lr = (k >= 32);
    d  = 1'b0;
    case (f)
      3'b011, 3'b100: if (j < w) d = s[w-1-j];
      3'b001:         if (j >= 32 - w) d = s[31-j];
      3'b010: begin
        lr = (k == 0);
        if (k >= 1 && k <= w) d = l[w-k];
        else if (k > w && k <= 2*w) d = r[2*w-k];
      end
      default:        if (j >= 1 && j <= w) d = s[w-j];
    endcase
    return {lr, d};
  endfunction

  task automatic send_bit(input logic lr, input logic d);
    bclk = 1'b0; lrclk = lr; sdata = d;
    repeat (4) @(negedge clk);
    bclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_frame(input vec_t v);
    logic [1:0] b;
    for (int k = 0; k < 64; k++) begin
      b = frame_bit(v.f, wbits(v.wc), v.l, v.r, k);
      send_bit(b[1], b[0]);
    end
  endtask

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [23:0] hl, hr;
    repeat (5) @(negedge clk);
    check("R1 left reset", lq, 24'h0);
    check("R1 right reset", rq, 24'h0);
    check("R1 strobes reset", {22'h0, lv, rv}, 24'h0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    for (int n = 0; n < NV; n++) begin
      fmt = VECS[n].f; wsel = VECS[n].wc;
      send_frame(VECS[n]);
      lcnt = 0; rcnt = 0;
      send_frame(VECS[n]);
      send_frame(VECS[n]);
      send_bit(1'b0, 1'b0);
      send_bit(1'b0, 1'b0);
      repeat (8) @(negedge clk);
      check($sformatf("R2/R3-R7 left v%0d", n), l_last,
            expect_ext(VECS[n].l, wbits(VECS[n].wc)));
      check($sformatf("R2/R3-R7 right v%0d", n), r_last,
            expect_ext(VECS[n].r, wbits(VECS[n].wc)));
      check($sformatf("R8 left count v%0d", n), 24'(lcnt), 24'd2);
      // R5: the previous frame's right word lands inside the window
      check($sformatf("R8 right count v%0d", n), 24'(rcnt),
            (VECS[n].f == 3'b001) ? 24'd3 : 24'd2);
    end
    check("R8 single-cycle strobes", 24'(dbl), 24'd0);

    // R9: data and channel clock move, bit clock held high
    hl = lq; hr = rq; lcnt = 0; rcnt = 0;
    for (int k = 0; k < 20; k++) begin
      lrclk = ~lrclk; sdata = ~sdata;
      repeat (6) @(negedge clk);
    end
    check("R9 no left strobe", 24'(lcnt), 24'd0);
    check("R9 no right strobe", 24'(rcnt), 24'd0);
    check("R9 left held", lq, hl);
    check("R9 right held", rq, hr);

    // R1: reset mid-stream clears outputs
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 left cleared", lq, 24'h0);
    check("R1 right cleared", rq, 24'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule